// File: doc/BRIEF.md
# Buffered-Reload Dual PWM Generator

This block drives two PWM outputs from one shared up-counter. Its prescaler divisor, counter modulus and both pulse widths are written into staging registers at any time. The active copies that the counter and the comparators use change only at a counter reload. A change is taken only if software has first armed a load-acknowledge bit. That bit can be set only by writing one right after a read that returned it as zero, and it clears itself once the transfer is done. The arming rule means that a half-written set of timing values is never used.

A control register holds three bits: run enable, load-acknowledge and reload-interrupt enable. A write-gate input decides whether that register can be read or written at all. Each reload sets a sticky reload flag, which is cleared by writing one to it. The flag drives the interrupt request only when the interrupt enable is set. Each output has an override bit that replaces the generator with a level written by software.

Software must arm load-acknowledge before it sets run enable, and it must not clear load-acknowledge in the same write that sets run enable.

Top module: `pwm_pair_reload`

## Requirements
- R1: Address 0x0 is the control register, with run enable in bit 7, load-acknowledge in bit 1 and interrupt enable in bit 0. Bits 6 to 2 read as zero, and all three bits are zero after reset.
- R2: While `wr_gate_i` is low, a read of address 0x0 returns 0x00 and a write to address 0x0 changes nothing. A read of address 0x0 with the gate low also does not count as the zero read that R3 requires.
- R3: Load-acknowledge becomes 1 only when a gated write puts 1 in bit 1 and the previous gated control access was a read that returned bit 1 as 0. Any other write of 1 leaves the bit unchanged, and a gated write of 0 clears it.
- R4: The staged values move into the active set only at a reload while load-acknowledge is 1, and load-acknowledge then clears by itself. The staged values are: prescale code at 0x2 bits 1:0, modulus at 0x3 (low byte) and 0x4 (bits 3:0), width 0 at 0x5/0x6, and width 1 at 0x7/0x8.
- R5: A reload happens on a prescaled tick while the counter equals the active modulus, and the counter then wraps to 0. The first clock with run enable set is always a reload. Each reload sets the flag at address 0x1 bit 0, and writing 1 to that bit clears it.
- R6: `irq_o` is the reload flag ANDed with the interrupt enable. The flag is set on every reload whatever the interrupt enable holds.
- R7: Active prescale code k (0 to 3) advances the counter once every 2^k clocks.
- R8: While running, output n is high when the counter is below active width n, or when width n is at least the modulus. A width of 0 keeps output n low.
- R9: With run enable clear, the counter does not advance, no reload occurs, and every output without override is low.
- R10: Address 0xF bit n enables override of output n, and bit 4+n gives the level it then drives, whether or not the generator is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_gate_i | input | 1 | Allows access to the control register when high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pwm_o | output | 2 | PWM outputs |
| irq_o | output | 1 | Reload interrupt request |

## Verification
If the arming state is wrong, the control readback shows it at once, and the outputs show it at the next reload, when the duty or period either changes or fails to change. If the prescaler or counter is wrong, `pwm_o` drifts from the reference within one counter period, and the reload flag and `irq_o` come in the wrong cycle. The bench compares the outputs, the interrupt and the readback against a behavioural model on every clock, so an internal error is caught in the first cycle it reaches a port.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'h0,
    A_STAT  = 4'h1,
    A_PRESC = 4'h2,
    A_MOD_L = 4'h3,
    A_MOD_H = 4'h4,
    A_W0_L  = 4'h5,
    A_OVR   = 4'hF
  } reg_addr_e;

  localparam int unsigned CTRL_EN_BIT  = 7;
  localparam int unsigned CTRL_LD_BIT  = 1;
  localparam int unsigned CTRL_IE_BIT  = 0;
  localparam int unsigned OVR_LVL_LSB  = 4;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pair_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned PRE_W = 2,
  parameter int unsigned N_OUT = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_gate_i,
  input  logic                         wr_en_i,
  input  logic                         rd_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic                         reload_i,
  output logic                         en_o,
  output logic                         ld_o,
  output logic                         ie_o,
  output logic                         seen_o,
  output logic                         flag_o,
  output logic [PRE_W-1:0]             stg_pre_o,
  output logic [CNT_W-1:0]             stg_mod_o,
  output logic [N_OUT-1:0][CNT_W-1:0]  stg_w_o,
  output logic [N_OUT-1:0]             ovr_en_o,
  output logic [N_OUT-1:0]             ovr_lvl_o
);
  localparam int unsigned HI_W   = CNT_W - 8;
  localparam int unsigned W_BASE = int'(A_W0_L);

  logic en_q, ld_q, ie_q, seen_q, flag_q;
  logic [PRE_W-1:0]            pre_q;
  logic [CNT_W-1:0]            mod_q;
  logic [N_OUT-1:0][CNT_W-1:0] w_q;
  logic [N_OUT-1:0]            ovr_en_q, ovr_lvl_q;

  logic ctrl_wr, ctrl_rd, stat_clr;
  assign ctrl_wr  = wr_en_i && wr_gate_i && (addr_i == A_CTRL);
  assign ctrl_rd  = rd_en_i && wr_gate_i && (addr_i == A_CTRL);
  assign stat_clr = wr_en_i && (addr_i == A_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ld_q   <= 1'b0;
      ie_q   <= 1'b0;
      seen_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q <= wdata_i[CTRL_EN_BIT];
        ie_q <= wdata_i[CTRL_IE_BIT];
      end
      // transfer wins over a same-cycle write
      if (reload_i && ld_q)
        ld_q <= 1'b0;
      else if (ctrl_wr)
        ld_q <= wdata_i[CTRL_LD_BIT] & (ld_q | seen_q);
      if (ctrl_wr)
        seen_q <= 1'b0;
      else if (ctrl_rd)
        seen_q <= ~ld_q;
      if (reload_i)
        flag_q <= 1'b1;
      else if (stat_clr)
        flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      mod_q     <= '0;
      ovr_en_q  <= '0;
      ovr_lvl_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_PRESC: pre_q <= wdata_i[PRE_W-1:0];
        A_MOD_L: mod_q[7:0] <= wdata_i;
        A_MOD_H: mod_q[CNT_W-1:8] <= wdata_i[HI_W-1:0];
        A_OVR: begin
          ovr_en_q  <= wdata_i[N_OUT-1:0];
          ovr_lvl_q <= wdata_i[OVR_LVL_LSB +: N_OUT];
        end
        default: ;
      endcase
    end
  end

  for (genvar n = 0; n < N_OUT; n++) begin : g_width
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(W_BASE + 2 * n);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(W_BASE + 2 * n + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        w_q[n] <= '0;
      else if (wr_en_i && addr_i == LO_A)
        w_q[n][7:0] <= wdata_i;
      else if (wr_en_i && addr_i == HI_A)
        w_q[n][CNT_W-1:8] <= wdata_i[HI_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: if (wr_gate_i) begin
        rdata_o[CTRL_EN_BIT] = en_q;
        rdata_o[CTRL_LD_BIT] = ld_q;
        rdata_o[CTRL_IE_BIT] = ie_q;
      end
      A_STAT:  rdata_o[0] = flag_q;
      A_PRESC: rdata_o[PRE_W-1:0] = pre_q;
      A_MOD_L: rdata_o = mod_q[7:0];
      A_MOD_H: rdata_o[HI_W-1:0] = mod_q[CNT_W-1:8];
      A_OVR: begin
        rdata_o[N_OUT-1:0]              = ovr_en_q;
        rdata_o[OVR_LVL_LSB +: N_OUT]   = ovr_lvl_q;
      end
      default: ;
    endcase
    for (int n = 0; n < N_OUT; n++) begin
      if (addr_i == ADDR_W'(W_BASE + 2 * n))
        rdata_o = w_q[n][7:0];
      if (addr_i == ADDR_W'(W_BASE + 2 * n + 1)) begin
        rdata_o = '0;
        rdata_o[HI_W-1:0] = w_q[n][CNT_W-1:8];
      end
    end
  end

  assign en_o      = en_q;
  assign ld_o      = ld_q;
  assign ie_o      = ie_q;
  assign seen_o    = seen_q;
  assign flag_o    = flag_q;
  assign stg_pre_o = pre_q;
  assign stg_mod_o = mod_q;
  assign stg_w_o   = w_q;
  assign ovr_en_o  = ovr_en_q;
  assign ovr_lvl_o = ovr_lvl_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned PRE_W = 2,
  parameter int unsigned N_OUT = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         ld_i,
  input  logic [PRE_W-1:0]             stg_pre_i,
  input  logic [CNT_W-1:0]             stg_mod_i,
  input  logic [N_OUT-1:0][CNT_W-1:0]  stg_w_i,
  output logic [CNT_W-1:0]             cnt_o,
  output logic [CNT_W-1:0]             act_mod_o,
  output logic [N_OUT-1:0][CNT_W-1:0]  act_w_o,
  output logic                         reload_o
);
  // largest divisor is 2**(2**PRE_W - 1)
  localparam int unsigned PC_W = (1 << PRE_W) - 1;

  logic [PC_W-1:0]             pre_cnt_q, limit;
  logic [PRE_W-1:0]            act_pre_q;
  logic [CNT_W-1:0]            cnt_q, act_mod_q;
  logic [N_OUT-1:0][CNT_W-1:0] act_w_q;
  logic                        tick;

  assign limit    = PC_W'((1 << act_pre_q) - 1);
  assign tick     = en_i && (pre_cnt_q >= limit);
  assign reload_o = tick && (cnt_q >= act_mod_q);

  // idle: park at the wrap point so the first running clock reloads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '1;
      cnt_q     <= '0;
    end else if (!en_i) begin
      pre_cnt_q <= '1;
      cnt_q     <= act_mod_q;
    end else if (tick) begin
      pre_cnt_q <= '0;
      cnt_q     <= reload_o ? '0 : cnt_q + 1'b1;
    end else begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_pre_q <= '0;
      act_mod_q <= '0;
      act_w_q   <= '0;
    end else if (reload_o && ld_i) begin
      act_pre_q <= stg_pre_i;
      act_mod_q <= stg_mod_i;
      act_w_q   <= stg_w_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign act_mod_o = act_mod_q;
  assign act_w_o   = act_w_q;
endmodule

// File: rtl/pwm_outgen.sv
module pwm_outgen #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic             ovr_en_i,
  input  logic             ovr_lvl_i,
  output logic             pwm_o
);
  logic gen;
  always_comb begin
    gen   = en_i && (width_i != '0) && ((cnt_i < width_i) || (width_i >= mod_i));
    pwm_o = ovr_en_i ? ovr_lvl_i : gen;
  end
endmodule

// File: rtl/pwm_pair_reload.sv
module pwm_pair_reload
  import pwm_pair_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned PRE_W = 2,
  parameter int unsigned N_OUT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_gate_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_OUT-1:0]  pwm_o,
  output logic              irq_o
);
  logic                        en_w, ld_w, ie_w, seen_w, flag_w, reload_w;
  logic [PRE_W-1:0]            stg_pre_w;
  logic [CNT_W-1:0]            stg_mod_w, cnt_w, act_mod_w;
  logic [N_OUT-1:0][CNT_W-1:0] stg_w_w, act_w_w;
  logic [N_OUT-1:0]            ovr_en_w, ovr_lvl_w;

  pwm_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .N_OUT(N_OUT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_gate_i (wr_gate_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .reload_i  (reload_w),
    .en_o      (en_w),
    .ld_o      (ld_w),
    .ie_o      (ie_w),
    .seen_o    (seen_w),
    .flag_o    (flag_w),
    .stg_pre_o (stg_pre_w),
    .stg_mod_o (stg_mod_w),
    .stg_w_o   (stg_w_w),
    .ovr_en_o  (ovr_en_w),
    .ovr_lvl_o (ovr_lvl_w)
  );

  pwm_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W), .N_OUT(N_OUT)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_w),
    .ld_i      (ld_w),
    .stg_pre_i (stg_pre_w),
    .stg_mod_i (stg_mod_w),
    .stg_w_i   (stg_w_w),
    .cnt_o     (cnt_w),
    .act_mod_o (act_mod_w),
    .act_w_o   (act_w_w),
    .reload_o  (reload_w)
  );

  for (genvar n = 0; n < N_OUT; n++) begin : g_out
    pwm_outgen #(.CNT_W(CNT_W)) u_out (
      .en_i      (en_w),
      .cnt_i     (cnt_w),
      .width_i   (act_w_w[n]),
      .mod_i     (act_mod_w),
      .ovr_en_i  (ovr_en_w[n]),
      .ovr_lvl_i (ovr_lvl_w[n]),
      .pwm_o     (pwm_o[n])
    );
  end

  assign irq_o = flag_w & ie_w;
endmodule

// File: rtl/pwm_pair_reload_chk.sv
module pwm_pair_reload_chk #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned N_OUT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_gate_i,
  input logic             wr_en_i,
  input logic [3:0]       addr_i,
  input logic [7:0]       rdata_o,
  input logic [N_OUT-1:0] pwm_o,
  input logic             irq_o,
  input logic             en_q,
  input logic             ld_q,
  input logic             ie_q,
  input logic             seen_q,
  input logic             flag_q,
  input logic             reload_w,
  input logic [CNT_W-1:0] act_mod_w,
  input logic [N_OUT-1:0] ovr_en_w
);
  a_r2_gated_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_gate_i && addr_i == 4'h0) |-> (rdata_o == 8'h00));

  a_r3_arm_needs_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_q) |-> $past(wr_en_i && wr_gate_i && addr_i == 4'h0 && seen_q));

  a_r4_arm_self_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_w && ld_q) |=> !ld_q);

  a_r4_active_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_w |=> $stable(act_mod_w));

  a_r5_flag_on_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_w |=> flag_q);

  a_r6_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(reload_w) || $rose(ie_q) || $rose(flag_q)));

  a_r9_no_reload_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !reload_w);

  for (genvar n = 0; n < N_OUT; n++) begin : g_idle
    a_r9_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_q && !ovr_en_w[n]) |-> !pwm_o[n]);
  end
endmodule

bind pwm_pair_reload pwm_pair_reload_chk #(.CNT_W(CNT_W), .N_OUT(N_OUT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_gate_i (wr_gate_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .pwm_o     (pwm_o),
  .irq_o     (irq_o),
  .en_q      (en_w),
  .ld_q      (ld_w),
  .ie_q      (ie_w),
  .seen_q    (seen_w),
  .flag_q    (flag_w),
  .reload_w  (reload_w),
  .act_mod_w (act_mod_w),
  .ovr_en_w  (ovr_en_w)
);

// File: tb/pwm_pair_reload_test.sv
module pwm_pair_reload_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_gate_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [3:0] addr_i = 4'h0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [1:0] pwm_o;
  logic       irq_o;

  always #5 clk_i = ~clk_i;

  pwm_pair_reload uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_gate_i(wr_gate_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  int m_en = 0, m_ld = 0, m_ie = 0, m_seen = 0, m_flag = 0;
  int s_pre = 0, s_mod = 0, a_pre = 0, a_mod = 0;
  int s_w[2] = '{0, 0};
  int a_w[2] = '{0, 0};
  int m_ovr = 0, m_pc = 1000, m_cnt = 0;

  function automatic int exp_pwm(int n);
    if (m_ovr[n]) return m_ovr[4+n];
    if (m_en == 0 || a_w[n] == 0) return 0;
    return (m_cnt < a_w[n] || a_w[n] >= a_mod) ? 1 : 0;
  endfunction

  function automatic int exp_rd();
    case (int'(addr_i))
      0: return wr_gate_i ? (m_en * 128 + m_ld * 2 + m_ie) : 0;
      1: return m_flag;
      2: return s_pre;
      3: return s_mod % 256;
      4: return s_mod / 256;
      5: return s_w[0] % 256;
      6: return s_w[0] / 256;
      7: return s_w[1] % 256;
      8: return s_w[1] / 256;
      15: return m_ovr;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_en = 0; m_ld = 0; m_ie = 0; m_seen = 0; m_flag = 0;
      s_pre = 0; s_mod = 0; a_pre = 0; a_mod = 0; m_ovr = 0;
      s_w = '{0, 0}; a_w = '{0, 0}; m_pc = 1000; m_cnt = 0;
    end else begin
      automatic int  div = 1 << a_pre;
      automatic bit  gw = wr_en_i && wr_gate_i && addr_i == 4'h0;
      automatic bit  gr = rd_en_i && wr_gate_i && addr_i == 4'h0;
      automatic int  o_ld = m_ld, o_seen = m_seen;
      automatic bit  rel = 0;
      if (m_en != 0) begin
        if (m_pc >= div - 1) begin
          m_pc = 0;
          if (m_cnt >= a_mod) begin m_cnt = 0; rel = 1; end
          else m_cnt++;
        end else m_pc++;
      end else begin
        m_pc = 1000;
        m_cnt = a_mod;
      end
      if (rel && o_ld != 0) begin
        a_pre = s_pre; a_mod = s_mod; a_w = s_w;
      end
      if (rel) m_flag = 1;
      else if (wr_en_i && addr_i == 4'h1 && wdata_i[0]) m_flag = 0;
      if (rel && o_ld != 0) m_ld = 0;
      else if (gw) m_ld = (wdata_i[1] && (o_ld != 0 || o_seen != 0)) ? 1 : 0;
      if (gw) begin
        m_en = wdata_i[7]; m_ie = wdata_i[0]; m_seen = 0;
      end else if (gr) m_seen = (o_ld == 0) ? 1 : 0;
      if (wr_en_i) begin
        case (int'(addr_i))
          2: s_pre = wdata_i[1:0];
          3: s_mod = (s_mod & 32'hF00) | wdata_i;
          4: s_mod = (s_mod & 32'h0FF) | (int'(wdata_i[3:0]) << 8);
          5: s_w[0] = (s_w[0] & 32'hF00) | wdata_i;
          6: s_w[0] = (s_w[0] & 32'h0FF) | (int'(wdata_i[3:0]) << 8);
          7: s_w[1] = (s_w[1] & 32'hF00) | wdata_i;
          8: s_w[1] = (s_w[1] & 32'h0FF) | (int'(wdata_i[3:0]) << 8);
          15: m_ovr = wdata_i & 8'h33;
          default: ;
        endcase
      end
    end
    #3;
    if (rst_ni) begin
      check("R8 R9 R10 pwm0", pwm_o[0], exp_pwm(0));
      check("R8 R9 R10 pwm1", pwm_o[1], exp_pwm(1));
      check("R6 irq", irq_o, (m_flag != 0 && m_ie != 0) ? 1 : 0);
      check("R1 R2 rdata", rdata_o, exp_rd());
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk_i);
    addr_i = 4'(a); wdata_i = 8'(d); wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk_i);
    addr_i = 4'(a); rd_en_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic count_high(int n, int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      hi += pwm_o[n];
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(0, v); check("R1 reset ctrl", v, 0);
    rd(1, v); check("R5 reset flag", v, 0);

    // R2: write-gate low
    wr_gate_i = 1'b0;
    wr(0, 8'h83);
    rd(0, v); check("R2 gated read", v, 0);
    wr_gate_i = 1'b1;
    rd(0, v); check("R2 gated write ignored", v, 0);

    // staged values: presc /1, mod 9, w0 4, w1 0
    wr(2, 0); wr(3, 9); wr(4, 0); wr(5, 4); wr(6, 0); wr(7, 0); wr(8, 0);
    rd(3, v); check("R4 staged modulus readback", v, 9);

    // R3: write one without a preceding zero read
    wr(0, 8'h00);
    wr(0, 8'h02);
    rd(0, v); check("R3 no zero read", v, 0);
    wr(0, 8'h02);
    rd(0, v); check("R3 armed", v, 2);

    // enable with interrupt, keep arm; first running clock reloads
    wr(0, 8'h83);
    rd(0, v); check("R4 self-clear", v, 8'h81);
    rd(1, v); check("R5 flag set", v, 1);
    check("R6 irq asserted", irq_o, 1);
    count_high(0, 10, v); check("R8 duty 4 of 10", v, 4);
    count_high(1, 10, v); check("R8 zero width low", v, 0);

    // R6: flag still sets with interrupt disabled
    wr(0, 8'h80);
    wr(1, 1);
    repeat (12) @(negedge clk_i);
    rd(1, v); check("R6 flag without enable", v, 1);
    check("R6 irq masked", irq_o, 0);

    // staged but not armed: no change
    wr(2, 1); wr(3, 5); wr(5, 7); wr(7, 2);
    repeat (25) @(negedge clk_i);
    count_high(0, 10, v); check("R4 not loaded without arm", v, 4);
    rd(0, v);
    wr(0, 8'h82);
    repeat (24) @(negedge clk_i);
    count_high(0, 12, v); check("R8 width over modulus", v, 12);
    count_high(1, 12, v); check("R7 divide by 2", v, 4);

    // manual clear of the arm before any reload
    wr(0, 8'h00);
    wr(2, 3);
    rd(0, v);
    wr(0, 8'h02);
    wr(0, 8'h00);
    rd(0, v); check("R3 manual clear", v, 0);
    wr(0, 8'h80);
    repeat (12) @(negedge clk_i);
    count_high(1, 12, v); check("R4 cleared arm not loaded", v, 4);

    // divide by 8
    rd(0, v);
    wr(0, 8'h82);
    repeat (60) @(negedge clk_i);
    count_high(1, 48, v); check("R7 divide by 8", v, 16);

    // R9 / R10
    wr(0, 8'h00);
    repeat (2) @(negedge clk_i);
    check("R9 idle outputs", pwm_o, 0);
    wr(15, 8'h13);
    check("R10 override levels", pwm_o, 1);
    wr(0, 8'h80);
    repeat (20) @(negedge clk_i);
    check("R10 override while running", pwm_o, 1);
    wr(15, 8'h00);
    repeat (30) @(negedge clk_i);
    summary();
  end
endmodule